// File: doc/BRIEF.md
# Speed-Pin Low-Power Entry and Wake Detector

This block watches the speed command of a motor controller and decides when the controller should give up driving and drop into a low-power state, and when it should come back. What counts as "low" and as "wake" depends on the speed-input mode. In analog mode the block reads two comparator flags: one says the input is below the entry threshold and the other says it is above the exit threshold. In PWM and frequency modes it reads the speed pin as a logic level. In host mode it reads the digital speed command that host software wrote. The block itself does no analog sensing and no speed decoding.

A free-running prescaler turns the system clock into a 1 µs tick, and every time window is counted in those ticks. A low condition that lasts for the selected entry window raises the low-power request. After a further stop window the drive enable is withdrawn. A high condition that lasts for the wake window produces a one-cycle wake event, clears any pending entry and restores the drive. All windows are parameters. The defaults are 50 µs, 200 µs, 20 ms and 200 ms for the four entry selections, 1 ms for host-mode detection, 1 µs for wake and 1 ms for the stop window.

Top module: `spd_lowpower_det`

## Requirements
- R1: After reset, `drive_en_o` is 1, `lp_req_o` is 0 and `wake_o` is 0.
- R2: `mode_i` selects where the low and high conditions come from:
  - 00 (analog): low is `ana_below_i`, high is `ana_above_i`.
  - 01 (PWM) and 11 (frequency): low is the speed pin at 0 and high is the pin at 1, after a two-flop synchronizer.
  - 10 (host): low is `dig_cmd_i` equal to zero, high is any non-zero value.
- R3: Outside host mode, `etime_i` selects the entry window: 00 gives ENTRY0_US, 01 gives ENTRY1_US, 10 gives ENTRY2_US and 11 gives ENTRY3_US. An unbroken low condition of that length raises `lp_req_o`; a shorter one does not.
- R4: In host mode the entry window is HOST_DET_US, whatever the value of `etime_i`.
- R5: In PWM mode every synchronized pin edge restarts the entry timer. A PWM train whose low phases are all shorter than the window never raises `lp_req_o`.
- R6: `drive_en_o` falls STOP_US after `lp_req_o` rises. `lp_req_o` stays 1 while the drive is off.
- R7: A high condition that holds for WAKE_US while `lp_req_o` is 1 produces a single-cycle `wake_o`. In the same cycle `lp_req_o` returns to 0 and `drive_en_o` returns to 1.
- R8: A high condition shorter than WAKE_US is ignored: the low-power state is kept.
- R9: A wake that qualifies inside the stop window cancels the entry, and `drive_en_o` never drops.
- R10: In analog mode, when both comparator flags are 1, the high condition wins and no entry timing takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spd_pin_i | input | 1 | Speed pin logic level (asynchronous) |
| ana_below_i | input | 1 | Analog comparator: input below entry threshold |
| ana_above_i | input | 1 | Analog comparator: input above exit threshold |
| dig_cmd_i | input | CMD_W | Host-written speed command |
| mode_i | input | 2 | Speed-input mode: 00 analog, 01 PWM, 10 host, 11 frequency |
| etime_i | input | 2 | Entry window select |
| lp_req_o | output | 1 | Low-power request |
| wake_o | output | 1 | One-cycle wake event |
| drive_en_o | output | 1 | Motor drive enable |

## Verification
The bench goes after the edges of each qualification window.

- Entry: it holds a low condition a few ticks short of the window and then a few ticks past it, for every `etime_i` code and for host mode. A wrong table decode or a timer that ignores the mode shows up as an early or missing request.
- PWM trains: it applies PWM trains with short low phases. A timer that kept counting across edges would end up requesting low power during normal running.
- Wake: it applies wake glitches shorter than the wake window, which a too-eager wake qualifier would accept.
- Stop-window cancel: it applies a wake inside the stop window. A design that let the stop timer finish regardless would cut the drive.
- Analog priority: it drives both comparator flags at once, which would start entry in a design that gave low priority over high.

// File: rtl/spd_lp_pkg.sv
package spd_lp_pkg;

  typedef enum logic [1:0] {
    MODE_ANALOG = 2'b00,
    MODE_PWM    = 2'b01,
    MODE_HOST   = 2'b10,
    MODE_FREQ   = 2'b11
  } spd_mode_e;

  typedef enum logic [1:0] {
    ST_RUN      = 2'b00,
    ST_STOPPING = 2'b01,
    ST_PARKED   = 2'b10
  } lp_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Entry window in 1 us ticks for a given mode and select code.
  function automatic int unsigned pick_entry_ticks(
    input logic [1:0]  mode,
    input logic [1:0]  sel,
    input int unsigned t0,
    input int unsigned t1,
    input int unsigned t2,
    input int unsigned t3,
    input int unsigned thost
  );
    if (mode == MODE_HOST) return thost;
    case (sel)
      2'b00:   return t0;
      2'b01:   return t1;
      2'b10:   return t2;
      default: return t3;
    endcase
  endfunction

endpackage

// File: rtl/spd_tick_gen.sv
module spd_tick_gen #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (pre_q == LAST);
      pre_q  <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/spd_cond_sel.sv
module spd_cond_sel import spd_lp_pkg::*; #(
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             below_i,
  input  logic             above_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [1:0]       mode_i,
  output logic             low_o,
  output logic             high_o,
  output logic             pwm_edge_o
);
  // sh_q[SYNC_N-1] is the synchronized level, sh_q[SYNC_N] its previous value
  logic [SYNC_N:0] sh_q;
  logic            lvl, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_N-1:0], pin_i};
  end

  assign lvl  = sh_q[SYNC_N-1];
  assign prev = sh_q[SYNC_N];

  always_comb begin
    low_o  = 1'b0;
    high_o = 1'b0;
    unique case (spd_mode_e'(mode_i))
      MODE_ANALOG: begin
        high_o = above_i;
        low_o  = below_i & ~above_i;   // high takes priority
      end
      MODE_HOST: begin
        high_o = (cmd_i != '0);
        low_o  = (cmd_i == '0);
      end
      MODE_PWM, MODE_FREQ: begin
        high_o = lvl;
        low_o  = ~lvl;
      end
    endcase
  end

  assign pwm_edge_o = (spd_mode_e'(mode_i) == MODE_PWM) && (lvl != prev);
endmodule

// File: rtl/spd_qual_timer.sv
module spd_qual_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] target_i,
  output logic         reached_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (tick_i && (cnt_q != '1))  cnt_q <= cnt_q + 1'b1;
  end

  assign reached_o = !clr_i && (cnt_q >= target_i);
endmodule

// File: rtl/spd_lowpower_det.sv
module spd_lowpower_det import spd_lp_pkg::*; #(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned CMD_W       = 8,
  parameter int unsigned ENTRY0_US   = 50,
  parameter int unsigned ENTRY1_US   = 200,
  parameter int unsigned ENTRY2_US   = 20_000,
  parameter int unsigned ENTRY3_US   = 200_000,
  parameter int unsigned HOST_DET_US = 1_000,
  parameter int unsigned WAKE_US     = 1,
  parameter int unsigned STOP_US     = 1_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spd_pin_i,
  input  logic             ana_below_i,
  input  logic             ana_above_i,
  input  logic [CMD_W-1:0] dig_cmd_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       etime_i,
  output logic             lp_req_o,
  output logic             wake_o,
  output logic             drive_en_o
);
  localparam int unsigned TICK_DIV = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int unsigned LONGEST  = umax(umax(umax(ENTRY0_US, ENTRY1_US), umax(ENTRY2_US, ENTRY3_US)),
                                          umax(HOST_DET_US, umax(WAKE_US, STOP_US)));
  localparam int unsigned CNT_W    = $clog2(LONGEST + 2);

  logic tick;
  logic low_c, high_c, pwm_edge;
  logic ent_clr, wk_clr, stop_clr;
  logic ent_hit, wk_hit, stop_done;
  logic [CNT_W-1:0] ent_target;
  lp_state_e st_q, st_d;
  logic wake_q;

  spd_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  spd_cond_sel #(.CMD_W(CMD_W), .SYNC_N(2)) u_cond (
    .clk(clk), .rst_n(rst_n), .pin_i(spd_pin_i),
    .below_i(ana_below_i), .above_i(ana_above_i), .cmd_i(dig_cmd_i),
    .mode_i(mode_i), .low_o(low_c), .high_o(high_c), .pwm_edge_o(pwm_edge)
  );

  assign ent_target = CNT_W'(pick_entry_ticks(mode_i, etime_i, ENTRY0_US, ENTRY1_US,
                                              ENTRY2_US, ENTRY3_US, HOST_DET_US));

  // Entry timer: counts only while running and low, restarted by PWM edges
  assign ent_clr  = (st_q != ST_RUN) || !low_c || pwm_edge;
  // Wake timer: counts only while in a low-power state and high
  assign wk_clr   = (st_q == ST_RUN) || !high_c;
  // Stop timer: counts the drive shutdown window
  assign stop_clr = (st_q != ST_STOPPING);

  spd_qual_timer #(.W(CNT_W)) u_ent (
    .clk(clk), .rst_n(rst_n), .clr_i(ent_clr), .tick_i(tick),
    .target_i(ent_target), .reached_o(ent_hit)
  );

  spd_qual_timer #(.W(CNT_W)) u_wake (
    .clk(clk), .rst_n(rst_n), .clr_i(wk_clr), .tick_i(tick),
    .target_i(CNT_W'(WAKE_US)), .reached_o(wk_hit)
  );

  spd_qual_timer #(.W(CNT_W)) u_stop (
    .clk(clk), .rst_n(rst_n), .clr_i(stop_clr), .tick_i(tick),
    .target_i(CNT_W'(STOP_US)), .reached_o(stop_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:      if (ent_hit) st_d = ST_STOPPING;
      ST_STOPPING: if (wk_hit) st_d = ST_RUN;
                   else if (stop_done) st_d = ST_PARKED;
      ST_PARKED:   if (wk_hit) st_d = ST_RUN;
      default:     st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      wake_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wake_q <= wk_hit;
    end
  end

  assign lp_req_o   = (st_q != ST_RUN);
  assign drive_en_o = (st_q != ST_PARKED);
  assign wake_o     = wake_q;
endmodule

// File: rtl/spd_lowpower_det_chk.sv
module spd_lowpower_det_chk (
  input logic clk,
  input logic rst_n,
  input logic lp_req_o,
  input logic wake_o,
  input logic drive_en_o
);
  AST_DRIVE_OFF_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en_o |-> lp_req_o);                                   // R6
  AST_REQ_BEFORE_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_en_o) |-> $past(lp_req_o));                      // R6
  AST_REQ_RISES_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_req_o) |-> drive_en_o);                             // R6
  AST_WAKE_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (!lp_req_o && drive_en_o));                       // R7
  AST_WAKE_FROM_LOWPOWER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_o) |-> $past(lp_req_o));                          // R7
  AST_WAKE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);                                         // R7
endmodule

bind spd_lowpower_det spd_lowpower_det_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lp_req_o(lp_req_o),
  .wake_o(wake_o), .drive_en_o(drive_en_o)
);

// File: tb/spd_lowpower_det_bench.sv
module spd_lowpower_det_bench;
  // Scaled timing: 4 clocks per "microsecond" tick, short windows.
  localparam int DIV  = 4;
  localparam int T0 = 5, T1 = 12, T2 = 30, T3 = 60, TH = 20, TW = 2, TS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1, below = 1'b0, above = 1'b0;
  logic [7:0] cmd = 8'd1;
  logic [1:0] mode = 2'b01, etime = 2'b00;
  logic lp_req, wake, drive_en;

  int vectors = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  spd_lowpower_det #(
    .CLK_HZ(DIV * 1_000_000), .CMD_W(8),
    .ENTRY0_US(T0), .ENTRY1_US(T1), .ENTRY2_US(T2), .ENTRY3_US(T3),
    .HOST_DET_US(TH), .WAKE_US(TW), .STOP_US(TS)
  ) u_spd_lowpower_det (
    .clk(clk), .rst_n(rst_n), .spd_pin_i(pin), .ana_below_i(below),
    .ana_above_i(above), .dig_cmd_i(cmd), .mode_i(mode), .etime_i(etime),
    .lp_req_o(lp_req), .wake_o(wake), .drive_en_o(drive_en)
  );

  // ---------------- behavioural reference model ----------------
  bit pipe[$];               // synchronizer history, newest first
  int m_pre, m_ent, m_wk, m_stp, m_st;  // m_st: 0 run, 1 stopping, 2 parked
  bit m_tick, m_wq;

  function automatic int window(input int md, input int sel);
    int tbl[4] = '{T0, T1, T2, T3};
    return (md == 2) ? TH : tbl[sel];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pipe = {0, 0, 0};
      m_pre = 0; m_ent = 0; m_wk = 0; m_stp = 0; m_st = 0; m_tick = 0; m_wq = 0;
    end else begin
      bit lv, ed, lo, hi, e_run, w_run, s_run, e_hit, w_hit, s_hit;
      int nst;
      lv = pipe[1];
      ed = (mode == 2'b01) && (pipe[1] != pipe[2]);
      case (mode)
        2'b00: begin hi = above; lo = below && !above; end
        2'b10: begin hi = (cmd != 0); lo = (cmd == 0); end
        default: begin hi = lv; lo = !lv; end
      endcase
      e_run = (m_st == 0) && lo && !ed;
      w_run = (m_st != 0) && hi;
      s_run = (m_st == 1);
      e_hit = e_run && (m_ent >= window(mode, etime));
      w_hit = w_run && (m_wk >= TW);
      s_hit = s_run && (m_stp >= TS);
      nst = m_st;
      if (m_st == 0 && e_hit) nst = 1;
      else if (m_st != 0 && w_hit) nst = 0;
      else if (m_st == 1 && s_hit) nst = 2;
      m_wq = w_hit;
      m_ent = e_run ? m_ent + m_tick : 0;
      m_wk  = w_run ? m_wk + m_tick : 0;
      m_stp = s_run ? m_stp + m_tick : 0;
      m_st  = nst;
      m_tick = (m_pre == DIV - 1);
      m_pre  = (m_pre == DIV - 1) ? 0 : m_pre + 1;
      pipe.push_front(pin);
      void'(pipe.pop_back());
    end
  end

  // ---------------- per-cycle comparison and event monitors ----------------
  int n_wake = 0, n_lp_rise = 0, n_drv_fall = 0;
  logic p_lp = 0, p_drv = 1;

  task automatic chk(input string req, input bit ok, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, drive_en == (m_st != 2), "model drive_en", drive_en, m_st != 2);
      chk(cur_req, lp_req == (m_st != 0), "model lp_req", lp_req, m_st != 0);
      chk(cur_req, wake == m_wq, "model wake", wake, m_wq);
      if (wake) n_wake++;
      if (lp_req && !p_lp) n_lp_rise++;
      if (!drive_en && p_drv) n_drv_fall++;
      p_lp = lp_req; p_drv = drive_en;
    end
  end

  task automatic wait_us(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  // Drives the low condition for the given mode, then checks both sides of the window.
  task automatic entry_window(input string req, input logic [1:0] md, input logic [1:0] sel, input int ticks);
    cur_req = req;
    @(negedge clk);
    mode = md; etime = sel;
    if (md == 2'b00) begin below = 1; above = 0; end
    else if (md == 2'b10) cmd = 0;
    else pin = 0;
    wait_us(ticks - 3);
    chk(req, lp_req == 0, "lp_req before window", lp_req, 0);
    wait_us(6);
    chk(req, lp_req == 1, "lp_req after window", lp_req, 1);
    // wake back to running
    if (md == 2'b00) begin below = 0; above = 1; end
    else if (md == 2'b10) cmd = 8'd7;
    else pin = 1;
    wait_us(5);
    chk("R7", lp_req == 0 && drive_en == 1, "state after wake", lp_req, 0);
    below = 0; above = 0;
  endtask

  initial begin
    int w0, r0, d0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", drive_en == 1, "reset drive_en", drive_en, 1);
    chk("R1", lp_req == 0, "reset lp_req", lp_req, 0);
    chk("R1", wake == 0, "reset wake", wake, 0);
    wait_us(3);

    // R3 / R6: PWM, shortest window, then full shutdown
    cur_req = "R6";
    pin = 0; etime = 2'b00;
    wait_us(T0 + 3);
    chk("R6", lp_req == 1 && drive_en == 1, "stopping: drive still on", drive_en, 1);
    wait_us(TS + 2);
    chk("R6", drive_en == 0, "drive_en after stop window", drive_en, 0);
    chk("R6", lp_req == 1, "lp_req held while parked", lp_req, 1);

    // R8: a wake glitch shorter than the wake window
    cur_req = "R8";
    pin = 1; repeat (DIV) @(negedge clk); pin = 0;
    wait_us(5);
    chk("R8", lp_req == 1 && drive_en == 0, "glitch ignored", lp_req, 1);

    // R7: real wake
    cur_req = "R7";
    w0 = n_wake;
    pin = 1;
    wait_us(1);
    chk("R7", lp_req == 1, "wake not yet qualified", lp_req, 1);
    wait_us(4);
    chk("R7", n_wake - w0 == 1, "single wake pulse", n_wake - w0, 1);
    chk("R7", lp_req == 0 && drive_en == 1, "running after wake", drive_en, 1);

    // R3 / R2: each entry select in PWM and frequency modes
    entry_window("R3", 2'b01, 2'b01, T1);
    entry_window("R3", 2'b01, 2'b10, T2);
    entry_window("R3", 2'b11, 2'b11, T3);
    entry_window("R2", 2'b11, 2'b00, T0);
    // R2: analog mode uses the comparator flag
    entry_window("R2", 2'b00, 2'b01, T1);
    // R4: host mode ignores the select code
    cmd = 8'd3;
    entry_window("R4", 2'b10, 2'b00, TH);
    cmd = 8'd3;

    // R5: PWM train with short low phases never enters
    cur_req = "R5";
    mode = 2'b01; etime = 2'b00; pin = 1;
    wait_us(3);
    r0 = n_lp_rise;
    for (int i = 0; i < 20; i++) begin
      pin = 0; wait_us(T0 - 2);
      pin = 1; wait_us(1);
    end
    chk("R5", n_lp_rise == r0, "no entry under PWM", n_lp_rise - r0, 0);

    // R10: analog with both flags set never enters
    cur_req = "R10";
    mode = 2'b00; below = 1; above = 1;
    wait_us(T0 * 3);
    chk("R10", n_lp_rise == r0, "high wins over low", n_lp_rise - r0, 0);
    below = 0; above = 0;
    mode = 2'b01; pin = 1;
    wait_us(3);

    // R9: wake inside the stop window cancels the shutdown
    cur_req = "R9";
    d0 = n_drv_fall; w0 = n_wake;
    pin = 0; wait_us(T0 + 3);
    chk("R9", lp_req == 1, "entered before cancel", lp_req, 1);
    pin = 1; wait_us(5);
    chk("R9", n_drv_fall == d0, "drive never dropped", n_drv_fall - d0, 0);
    chk("R9", n_wake - w0 == 1, "cancel wake pulse", n_wake - w0, 1);
    chk("R9", lp_req == 0 && drive_en == 1, "running after cancel", lp_req, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(150_000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired in %s actual=hung expected=finish", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule